// File: doc/BRIEF.md
# Virtual-8086 Sensitive-Operation Trap Checker

This block gives a verdict for a single instruction decoded while the processor runs a virtual-8086 task. The task always runs at privilege level 3. The verdict is either "execute" or "raise a general protection fault". The decoder describes the operation with a class code and the operands that matter. The block answers with a one-cycle verdict strobe. Operations that touch the interrupt flag and software interrupts are judged from the task's I/O privilege level and, for software interrupts, also from the gate's descriptor privilege level. Port I/O ignores the privilege level entirely and is judged only by the per-port permission bitmap.

The permission bitmap sits outside the block behind a registered read port. A bit requested in one cycle is returned in the next. A word or dword port access covers several byte ports, and the block fetches one bit per covered port, one read per cycle, in ascending port order. The access faults if any covered bit is set. It also faults, without any read, if any covered port lies above the bitmap limit input. The request side is a valid/ready handshake. `req_ready` is high only while no bitmap fetch is in progress. A request is taken in a cycle where both `req_valid` and `req_ready` are high. While `req_ready` is low, `req_valid` and the request fields are ignored and are not held. The verdict has no back-pressure: `verdict_valid` is high for exactly one cycle per accepted request.

Top module: `v86_trap_check`

## Requirements
- R1: After reset, `verdict_valid` and `bm_rd_en` are low and `req_ready` is high.
- R2: Class 0 (interrupt-flag operations: PUSHF, POPF, INT n, IRET, STI, CLI) with an I/O privilege level of 0, 1 or 2 gives a fault verdict in the cycle after acceptance.
- R3: Class 0 with an I/O privilege level of 3 gives an execute verdict in the cycle after acceptance.
- R4: Class 1 (INT n through a gate) faults when the I/O privilege level is below 3 or when the gate DPL is below 3. It executes only when both are 3. The verdict comes in the cycle after acceptance.
- R5: For class 2 (port I/O), the I/O privilege level and the gate DPL have no effect on the verdict. A clear bitmap bit allows the access and a set bit faults it.
- R6: The port size code is 0 for a byte, 1 for a word, and 2 or 3 for a dword, giving N = 1, 2 or 4 covered ports. A class 2 access within the limit reads ports P..P+N-1, one per cycle, in ascending order, starting the cycle after acceptance. It faults if any of those bits is set. The verdict appears N+2 cycles after the request cycle.
- R7: If any covered port number exceeds `io_limit`, which includes a carry past the top of the 16-bit port space, the class 2 access faults in the cycle after acceptance and makes no bitmap read.
- R8: `req_ready` is low from the cycle after a port access that needs reads is accepted until its verdict cycle. Requests offered while `req_ready` is low produce no verdict. Each accepted request gives exactly one single-cycle verdict.
- R9: Class 3 (any other operation) always executes, and its verdict comes in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request will be taken |
| req_class | input | 2 | 0 interrupt-flag op, 1 INT n, 2 port I/O, 3 other |
| req_iopl | input | 2 | I/O privilege level of the task |
| req_gate_dpl | input | 2 | DPL of the interrupt gate (class 1) |
| req_port | input | PORT_W | First port number (class 2) |
| req_size | input | 2 | Port access size code (class 2) |
| io_limit | input | PORT_W | Highest port number covered by the bitmap |
| bm_rd_en | output | 1 | Bitmap read strobe |
| bm_rd_addr | output | PORT_W | Port number whose bit is read |
| bm_rd_bit | input | 1 | Bitmap bit, returned the cycle after the strobe |
| verdict_valid | output | 1 | One-cycle verdict strobe |
| verdict_fault | output | 1 | 1 = general protection fault, 0 = execute |

## Verification
Counted from the cycle in which the request is presented, verdicts for classes 0, 1 and 3 and for port accesses over the limit are due one cycle later. A port access that needs the bitmap is due N+2 cycles later, and its reads fall in cycles 1 through N. For every request the bench counts cycles from the request to the first verdict strobe, sampling at falling edges. It compares that count with the expected latency as well as comparing the fault bit. It also logs every bitmap read address and checks the logged sequence against the expected ascending run, or against no reads at all.

// File: rtl/v86_trap_pkg.sv
package v86_trap_pkg;

  typedef enum logic [1:0] {
    CLS_IFLAG  = 2'd0,
    CLS_SWINT  = 2'd1,
    CLS_PORTIO = 2'd2,
    CLS_PLAIN  = 2'd3
  } op_class_e;

  localparam logic [1:0] TASK_PL        = 2'd3;
  localparam int         MAX_ACC_BYTES  = 4;
  localparam int         ACC_CNT_W      = $clog2(MAX_ACC_BYTES + 1);

  function automatic logic [ACC_CNT_W-1:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_to_bytes = ACC_CNT_W'(1);
      2'd1:    size_to_bytes = ACC_CNT_W'(2);
      default: size_to_bytes = ACC_CNT_W'(MAX_ACC_BYTES);
    endcase
  endfunction

endpackage

// File: rtl/v86_gate_rules.sv
module v86_gate_rules
  import v86_trap_pkg::*;
(
  input  op_class_e  cls,
  input  logic [1:0] iopl,
  input  logic [1:0] gate_dpl,
  output logic       fault
);

  logic iopl_short;
  logic dpl_short;

  assign iopl_short = (iopl != TASK_PL);
  assign dpl_short  = (gate_dpl < TASK_PL);

  always_comb begin
    case (cls)
      CLS_IFLAG: fault = iopl_short;
      CLS_SWINT: fault = iopl_short | dpl_short;
      default:   fault = 1'b0;
    endcase
  end

endmodule

// File: rtl/v86_io_seq.sv
module v86_io_seq
  import v86_trap_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PORT_W-1:0]    port_in,
  input  logic [ACC_CNT_W-1:0] nbytes_in,
  input  logic [PORT_W-1:0]    limit_in,
  output logic                 busy,
  output logic                 bm_rd_en,
  output logic [PORT_W-1:0]    bm_rd_addr,
  input  logic                 bm_rd_bit,
  output logic                 done,
  output logic                 fault
);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_DRAIN} seq_state_e;

  seq_state_e           state_q;
  logic [PORT_W-1:0]    base_q;
  logic [PORT_W-1:0]    lim_q;
  logic [ACC_CNT_W-1:0] idx_q;
  logic [ACC_CNT_W-1:0] left_q;
  logic                 pend_q;
  logic                 acc_q;
  logic                 done_q;
  logic                 fault_q;
  logic [PORT_W:0]      last_port;
  logic                 over;

  assign last_port = {1'b0, port_in} + (PORT_W+1)'(nbytes_in) - (PORT_W+1)'(1);
  assign over      = last_port > {1'b0, limit_in};

  assign busy       = (state_q != S_IDLE);
  assign bm_rd_en   = (state_q == S_READ);
  assign bm_rd_addr = base_q + PORT_W'(idx_q);
  assign done       = done_q;
  assign fault      = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      base_q  <= '0;
      lim_q   <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      acc_q   <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      pend_q <= bm_rd_en;
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            if (over) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              state_q <= S_READ;
              base_q  <= port_in;
              lim_q   <= limit_in;
              idx_q   <= '0;
              left_q  <= nbytes_in;
              acc_q   <= 1'b0;
            end
          end
        end
        S_READ: begin
          if (pend_q) acc_q <= acc_q | bm_rd_bit;
          idx_q  <= idx_q + ACC_CNT_W'(1);
          left_q <= left_q - ACC_CNT_W'(1);
          if (left_q == ACC_CNT_W'(1)) state_q <= S_DRAIN;
        end
        S_DRAIN: begin
          done_q  <= 1'b1;
          fault_q <= acc_q | bm_rd_bit;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_rd_in_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> (bm_rd_addr <= lim_q));

  assert_rd_ascend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_rd_en && $past(bm_rd_en)) |-> (bm_rd_addr == $past(bm_rd_addr) + PORT_W'(1)));

  assert_over_noread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && over) |=> (done && fault && !bm_rd_en));

  assert_drain_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DRAIN) |=> (done && !busy));

endmodule

// File: rtl/v86_trap_check.sv
module v86_trap_check
  import v86_trap_pkg::*;
#(
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_class,
  input  logic [1:0]        req_iopl,
  input  logic [1:0]        req_gate_dpl,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_size,
  input  logic [PORT_W-1:0] io_limit,
  output logic              bm_rd_en,
  output logic [PORT_W-1:0] bm_rd_addr,
  input  logic              bm_rd_bit,
  output logic              verdict_valid,
  output logic              verdict_fault
);

  op_class_e cls;
  logic      accept;
  logic      io_start;
  logic      io_busy;
  logic      io_done;
  logic      io_fault;
  logic      rule_fault;
  logic      fast_v_q;
  logic      fast_f_q;

  assign cls       = op_class_e'(req_class);
  assign req_ready = !io_busy;
  assign accept    = req_valid && req_ready;
  assign io_start  = accept && (cls == CLS_PORTIO);

  v86_gate_rules u_rules (
    .cls      (cls),
    .iopl     (req_iopl),
    .gate_dpl (req_gate_dpl),
    .fault    (rule_fault)
  );

  v86_io_seq #(.PORT_W(PORT_W)) u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (io_start),
    .port_in    (req_port),
    .nbytes_in  (size_to_bytes(req_size)),
    .limit_in   (io_limit),
    .busy       (io_busy),
    .bm_rd_en   (bm_rd_en),
    .bm_rd_addr (bm_rd_addr),
    .bm_rd_bit  (bm_rd_bit),
    .done       (io_done),
    .fault      (io_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_v_q <= 1'b0;
      fast_f_q <= 1'b0;
    end else begin
      fast_v_q <= accept && (cls != CLS_PORTIO);
      fast_f_q <= rule_fault;
    end
  end

  assign verdict_valid = fast_v_q | io_done;
  assign verdict_fault = fast_v_q ? fast_f_q : io_fault;

  assert_iflag_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_class == 2'd0 && req_iopl != 2'd3) |=> (verdict_valid && verdict_fault));

  assert_iflag_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_class == 2'd0 && req_iopl == 2'd3) |=> (verdict_valid && !verdict_fault));

  assert_swint_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_class == 2'd1 && (req_iopl != 2'd3 || req_gate_dpl != 2'd3))
      |=> (verdict_valid && verdict_fault));

  assert_plain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_class == 2'd3) |=> (verdict_valid && !verdict_fault));

  assert_one_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fast_v_q && io_done));

  assert_verdict_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    verdict_valid |-> req_ready);

  assert_no_read_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bm_rd_en |-> !req_ready);

endmodule

// File: tb/v86_trap_check_test.sv
module v86_trap_check_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_class = '0;
  logic [1:0]  req_iopl = '0;
  logic [1:0]  req_gate_dpl = '0;
  logic [15:0] req_port = '0;
  logic [1:0]  req_size = '0;
  logic [15:0] io_limit = '0;
  logic        bm_rd_en;
  logic [15:0] bm_rd_addr;
  logic        bm_rd_bit = 1'b0;
  logic        verdict_valid;
  logic        verdict_fault;

  int errors = 0;
  int checks = 0;
  logic perm [0:1023];
  logic [15:0] rd_log [0:15];
  int rd_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  v86_trap_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_class(req_class), .req_iopl(req_iopl), .req_gate_dpl(req_gate_dpl),
    .req_port(req_port), .req_size(req_size), .io_limit(io_limit),
    .bm_rd_en(bm_rd_en), .bm_rd_addr(bm_rd_addr), .bm_rd_bit(bm_rd_bit),
    .verdict_valid(verdict_valid), .verdict_fault(verdict_fault)
  );

  always @(posedge clk) begin
    if (bm_rd_en) begin
      bm_rd_bit <= perm[bm_rd_addr[9:0]];
      if (rd_n < 16) rd_log[rd_n] = bm_rd_addr;
      rd_n = rd_n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit over_limit(input logic [15:0] p, input logic [1:0] sz,
                                    input logic [15:0] lim);
    return (int'(p) + nbytes(sz) - 1) > int'(lim);
  endfunction

  function automatic int exp_fault(input logic [1:0] c, input logic [1:0] iopl,
      input logic [1:0] dpl, input logic [15:0] p, input logic [1:0] sz,
      input logic [15:0] lim);
    int f;
    case (c)
      2'd0: return (iopl != 2'd3) ? 1 : 0;
      2'd1: return (iopl != 2'd3 || dpl != 2'd3) ? 1 : 0;
      2'd3: return 0;
      default: begin
        if (over_limit(p, sz, lim)) return 1;
        f = 0;
        for (int i = 0; i < nbytes(sz); i++) if (perm[(int'(p) + i) % 1024]) f = 1;
        return f;
      end
    endcase
  endfunction

  function automatic int exp_lat(input logic [1:0] c, input logic [15:0] p,
      input logic [1:0] sz, input logic [15:0] lim);
    if (c != 2'd2 || over_limit(p, sz, lim)) return 1;
    return nbytes(sz) + 2;
  endfunction

  // Offers one request; busy_poke offers a stray request while the block is busy.
  task automatic run_req(input string tag, input logic [1:0] c, input logic [1:0] iopl,
      input logic [1:0] dpl, input logic [15:0] p, input logic [1:0] sz,
      input logic [15:0] lim, input bit busy_poke);
    int lat;
    int ef;
    int el;
    int nr;
    @(negedge clk);
    ef = exp_fault(c, iopl, dpl, p, sz, lim);
    el = exp_lat(c, p, sz, lim);
    nr = (el > 1) ? nbytes(sz) : 0;
    check({tag, " ready before request R8"}, int'(req_ready), 1);
    req_valid = 1'b1; req_class = c; req_iopl = iopl; req_gate_dpl = dpl;
    req_port = p; req_size = sz; io_limit = lim;
    rd_n = 0;
    lat = 0;
    while (lat < 12) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
      req_valid = 1'b0;
      if (busy_poke && lat == 2) begin
        check({tag, " ready low while fetching R8"}, int'(req_ready), 0);
        req_valid = 1'b1; req_class = 2'd3;
      end
      if (verdict_valid) break;
    end
    req_valid = 1'b0;
    check({tag, " verdict latency R6"}, lat, el);
    check({tag, " verdict fault"}, int'(verdict_fault), ef);
    check({tag, " bitmap read count R6/R7"}, rd_n, nr);
    for (int i = 0; i < nr && i < 16; i++)
      check({tag, " bitmap read address R6"}, int'(rd_log[i]), int'(p) + i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2667));
    for (int i = 0; i < 1024; i++) perm[i] = 1'b0;
    perm[101] = 1'b1;
    perm[203] = 1'b1;
    repeat (3) @(negedge clk);
    check("reset verdict_valid R1", int'(verdict_valid), 0);
    check("reset req_ready R1", int'(req_ready), 1);
    check("reset bm_rd_en R1", int'(bm_rd_en), 0);
    rst_n = 1'b1;

    for (int l = 0; l < 3; l++)
      run_req("R2 iflag low iopl", 2'd0, 2'(l), 2'd3, 16'd0, 2'd0, 16'd0, 1'b0);
    run_req("R3 iflag iopl3", 2'd0, 2'd3, 2'd0, 16'd0, 2'd0, 16'd0, 1'b0);
    run_req("R4 int ok", 2'd1, 2'd3, 2'd3, 16'd0, 2'd0, 16'd0, 1'b0);
    run_req("R4 int dpl0", 2'd1, 2'd3, 2'd0, 16'd0, 2'd0, 16'd0, 1'b0);
    run_req("R4 int iopl1", 2'd1, 2'd1, 2'd3, 16'd0, 2'd0, 16'd0, 1'b0);
    run_req("R9 plain", 2'd3, 2'd0, 2'd0, 16'd0, 2'd0, 16'd0, 1'b0);
    run_req("R5 io clear iopl0", 2'd2, 2'd0, 2'd0, 16'd50, 2'd0, 16'd1023, 1'b0);
    run_req("R5 io set iopl3", 2'd2, 2'd3, 2'd3, 16'd101, 2'd0, 16'd1023, 1'b0);
    run_req("R6 word upper set", 2'd2, 2'd3, 2'd3, 16'd100, 2'd1, 16'd1023, 1'b0);
    run_req("R6 dword last set", 2'd2, 2'd0, 2'd0, 16'd200, 2'd2, 16'd1023, 1'b0);
    run_req("R6 dword code3 clear", 2'd2, 2'd0, 2'd0, 16'd300, 2'd3, 16'd1023, 1'b0);
    run_req("R7 byte at limit", 2'd2, 2'd0, 2'd0, 16'd500, 2'd0, 16'd500, 1'b0);
    run_req("R7 word past limit", 2'd2, 2'd0, 2'd0, 16'd500, 2'd1, 16'd500, 1'b0);
    run_req("R7 dword wraps top", 2'd2, 2'd3, 2'd3, 16'hFFFF, 2'd2, 16'hFFFF, 1'b0);
    run_req("R8 stray while busy", 2'd2, 2'd0, 2'd0, 16'd400, 2'd2, 16'd1023, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 no verdict for ignored request", int'(verdict_valid), 0);
    end

    for (int i = 0; i < 1024; i++) perm[i] = ($urandom() % 6 == 0);
    for (int n = 0; n < 200; n++) begin
      logic [15:0] lim;
      logic [15:0] p;
      lim = 16'($urandom() % 1024);
      p   = ($urandom() % 8 == 0) ? 16'(lim - 16'($urandom() % 3)) : 16'($urandom() % 1100);
      run_req("random", 2'($urandom()), 2'($urandom()), 2'($urandom()), p,
              2'($urandom()), lim, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule